// File: doc/BRIEF.md
# Quadrature Tone Generator with Mixer Pre-Compensation

This block produces a digital low-frequency quadrature tone for the two D/A converters that feed an analog I/Q up-mixer. The mixer local oscillator runs at one fixed frequency, so all tuning happens here. A phase accumulator advances by a programmable tuning word every clock, and its upper bits address a quarter-wave sine table that yields a cosine and a sine sample for each phase.

Before the samples leave the block they are pre-distorted to cancel the analog stage's flaws. Gain mismatch, phase skew and LO feed-through in the mixer would otherwise leave an image tone and a carrier tone beside the wanted one. The pre-distortion has a fixed shape. The I branch is cosine plus a programmable cross term times sine plus a DC offset. The Q branch is a programmable gain times sine plus its own DC offset. The cosine weight on I is fixed at one and the cosine weight on Q at zero. For cancellation, each DC offset is set to the negative of the leakage level on its branch. Adaptation logic outside the block tunes the four coefficients. It uses a one-clock strobe that marks each accumulator wrap, which is one tone period.

Top module: `iq_tone_precomp`

## Requirements
- R1: While `rst` is high, `i_out`, `q_out`, `out_valid` and `cyc_strobe` are 0. After release, `out_valid` stays low at the first two rising edges and goes high at the third.
- R2: The 24-bit phase is 0 at reset and grows by `ftw` modulo 2^24 on every clock. The sample made from a phase value reaches the outputs exactly 3 clocks after that value is in the accumulator.
- R3: With `xterm`=0, `qgain`=16384, `dc_i`=0 and `dc_q`=0, `i_out`=C(p) and `q_out`=S(p). Here p is phase bits 23:14, S(p)=round(2047·sin(2π(p+0.5)/1024)) and C(p)=S((p+256) mod 1024).
- R4: `i_out` = sat(floor((C·2^14 + xterm·S + dc_i·2^11 + 2^13) / 2^14)). All coefficients are signed 16-bit with 14 fraction bits, and the cosine weight is fixed at one.
- R5: `q_out` = sat(floor((qgain·S + dc_q·2^11 + 2^13) / 2^14)). The cosine sample has no effect on Q, so with `qgain`=0 the output is a constant set by `dc_q` alone.
- R6: Rounding is half-up at one single point per branch. A `dc_i` of +4 (exactly half an LSB) raises I by one, and a `dc_i` of -4 leaves I unchanged.
- R7: Results outside the signed 12-bit range clip to 2047 or -2048.
- R8: `cyc_strobe` is high for one clock, together with the output sample whose phase came from an accumulator addition that overflowed 2^24.
- R9: With `ftw`=0 the phase holds, the outputs stay constant and `cyc_strobe` stays low.
- R10: A new `ftw` changes the step size from the next clock without resetting the phase.
- R11: Once `out_valid` is high, it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ftw | input | 24 | Frequency tuning word added to the phase each clock |
| xterm | input | 16 | Signed cross coefficient: sine into the I branch |
| qgain | input | 16 | Signed Q-branch sine gain |
| dc_i | input | 16 | Signed I-branch DC offset |
| dc_q | input | 16 | Signed Q-branch DC offset |
| i_out | output | 12 | Compensated I sample, signed |
| q_out | output | 12 | Compensated Q sample, signed |
| out_valid | output | 1 | Output samples are valid |
| cyc_strobe | output | 1 | One-clock mark of a phase wrap, aligned with the samples |

## Verification
The identity setting is checked first, at a slow tuning word, against an independently computed sine model for every clock. This separates table, folding and latency errors from compensation errors. Small cross and offset values then expose wrong term weighting. Exact half-LSB offsets tell half-up rounding apart from truncation or round-to-even. A zero Q gain with a DC offset shows whether cosine leaks into Q. Extreme coefficients drive both clip limits. A coarse tuning word lines up wraps with the strobe, a zero word shows the frozen phase, and a retune in mid-run shows whether the phase stays continuous.

// File: rtl/iqp_pkg.sv
package iqp_pkg;
   // register stages between accumulator and outputs
   localparam int unsigned IQP_PIPE = 3;

   // quadrant of the table address
   typedef enum logic [1:0] {
      QD_0 = 2'd0,
      QD_1 = 2'd1,
      QD_2 = 2'd2,
      QD_3 = 2'd3
   } quad_e;
endpackage

// File: rtl/iqp_phase_acc.sv
module iqp_phase_acc #(
   parameter int ACC_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] ftw,
   output logic [ACC_W-1:0] phase,
   output logic             wrap
);
   logic [ACC_W:0] sum;
   assign sum = {1'b0, phase} + {1'b0, ftw};

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= '0;
         wrap  <= 1'b0;
      end else begin
         phase <= sum[ACC_W-1:0];
         wrap  <= sum[ACC_W];
      end
   end
endmodule

// File: rtl/iqp_quad_lut.sv
module iqp_quad_lut
   import iqp_pkg::*;
#(
   parameter int AW     = 10,
   parameter int SW     = 12,
   parameter int OFFSET = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [AW-1:0]        addr,
   output logic signed [SW-1:0] sample
);
   localparam int  QA   = AW - 2;
   localparam int  QD   = 1 << QA;
   localparam int  MAGW = SW - 1;
   localparam real AMP  = real'((2 ** MAGW) - 1);

   if (AW < 3) begin : g_bad_aw
      $error("iqp_quad_lut: AW must be at least 3");
   end

   logic [MAGW-1:0] qtab [QD];

   for (genvar gi = 0; gi < QD; gi++) begin : g_tab
      localparam real ANG = 6.283185307179586 * (real'(gi) + 0.5) / real'(4 * QD);
      localparam int  VAL = $rtoi(AMP * $sin(ANG) + 0.5);
      assign qtab[gi] = MAGW'(VAL);
   end

   logic [AW-1:0] idx;
   quad_e         qd;
   logic [QA-1:0] k;
   logic [MAGW-1:0] mag;
   logic          neg;

   assign idx = addr + AW'(OFFSET);
   assign qd  = quad_e'(idx[AW-1 -: 2]);
   assign k   = idx[QA-1:0];
   assign mag = (qd == QD_1 || qd == QD_3) ? qtab[~k] : qtab[k];
   assign neg = (qd == QD_2 || qd == QD_3);

   always_ff @(posedge clk) begin
      if (rst) sample <= '0;
      else     sample <= neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
   end
endmodule

// File: rtl/iqp_precomp.sv
module iqp_precomp #(
   parameter int SW = 12,
   parameter int CW = 16,
   parameter int CF = 14
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic signed [SW-1:0] cos_s,
   input  logic signed [SW-1:0] sin_s,
   input  logic signed [CW-1:0] xterm,
   input  logic signed [CW-1:0] qgain,
   input  logic signed [CW-1:0] dc_i,
   input  logic signed [CW-1:0] dc_q,
   output logic signed [SW-1:0] i_out,
   output logic signed [SW-1:0] q_out
);
   localparam int PW  = CW + SW + 2;
   localparam int OSH = SW - 1;
   localparam logic signed [PW-1:0] RND  = PW'(1) <<< (CF - 1);
   localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (SW - 1)) - PW'(1);
   localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (SW - 1));

   logic signed [PW-1:0] c_x, s_x;
   assign c_x = $signed({{(PW-SW){cos_s[SW-1]}}, cos_s});
   assign s_x = $signed({{(PW-SW){sin_s[SW-1]}}, sin_s});

   logic signed [SW-1:0] lane_out [2];

   for (genvar gl = 0; gl < 2; gl++) begin : g_lane
      logic signed [PW-1:0] base, cf, of, acc_q, shf;

      if (gl == 0) begin : g_ibr
         assign base = c_x <<< CF;
         assign cf   = $signed({{(PW-CW){xterm[CW-1]}}, xterm});
         assign of   = $signed({{(PW-CW){dc_i[CW-1]}}, dc_i});
      end else begin : g_qbr
         assign base = '0;
         assign cf   = $signed({{(PW-CW){qgain[CW-1]}}, qgain});
         assign of   = $signed({{(PW-CW){dc_q[CW-1]}}, dc_q});
      end

      always_ff @(posedge clk) begin
         if (rst) acc_q <= '0;
         else     acc_q <= base + cf * s_x + (of <<< OSH) + RND;
      end

      assign shf = acc_q >>> CF;

      always_ff @(posedge clk) begin
         if (rst)              lane_out[gl] <= '0;
         else if (shf > MAXV)  lane_out[gl] <= MAXV[SW-1:0];
         else if (shf < MINV)  lane_out[gl] <= MINV[SW-1:0];
         else                  lane_out[gl] <= $signed(shf[SW-1:0]);
      end
   end

   assign i_out = lane_out[0];
   assign q_out = lane_out[1];
endmodule

// File: rtl/iq_tone_precomp.sv
module iq_tone_precomp
   import iqp_pkg::*;
#(
   parameter int ACC_W   = 24,
   parameter int LUT_AW  = 10,
   parameter int SMP_W   = 12,
   parameter int CF_W    = 16,
   parameter int CF_FRAC = 14
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ACC_W-1:0]        ftw,
   input  logic signed [CF_W-1:0]  xterm,
   input  logic signed [CF_W-1:0]  qgain,
   input  logic signed [CF_W-1:0]  dc_i,
   input  logic signed [CF_W-1:0]  dc_q,
   output logic signed [SMP_W-1:0] i_out,
   output logic signed [SMP_W-1:0] q_out,
   output logic                    out_valid,
   output logic                    cyc_strobe
);
   localparam int QUARTER = 1 << (LUT_AW - 2);
   localparam int PD      = int'(IQP_PIPE);

   if (LUT_AW > ACC_W) begin : g_bad_acc
      $error("iq_tone_precomp: LUT_AW exceeds ACC_W");
   end
   if (CF_FRAC >= CF_W || CF_FRAC < 1) begin : g_bad_cf
      $error("iq_tone_precomp: CF_FRAC out of range");
   end
   if (SMP_W < 4) begin : g_bad_sw
      $error("iq_tone_precomp: SMP_W too small");
   end

   logic [ACC_W-1:0] phase;
   logic             wrap_r;

   iqp_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst   (rst),
      .ftw   (ftw),
      .phase (phase),
      .wrap  (wrap_r)
   );

   logic [ACC_W-LUT_AW-1:0] unused_lsb;
   assign unused_lsb = phase[ACC_W-LUT_AW-1:0];

   // index 0 = cosine (quarter-turn ahead), index 1 = sine
   logic signed [SMP_W-1:0] smp [2];

   for (genvar gb = 0; gb < 2; gb++) begin : g_br
      iqp_quad_lut #(
         .AW     (LUT_AW),
         .SW     (SMP_W),
         .OFFSET ((gb == 0) ? QUARTER : 0)
      ) u_lut (
         .clk    (clk),
         .rst    (rst),
         .addr   (phase[ACC_W-1 -: LUT_AW]),
         .sample (smp[gb])
      );
   end

   iqp_precomp #(.SW(SMP_W), .CW(CF_W), .CF(CF_FRAC)) u_comp (
      .clk   (clk),
      .rst   (rst),
      .cos_s (smp[0]),
      .sin_s (smp[1]),
      .xterm (xterm),
      .qgain (qgain),
      .dc_i  (dc_i),
      .dc_q  (dc_q),
      .i_out (i_out),
      .q_out (q_out)
   );

   logic [PD-1:0] vpipe, wpipe;

   always_ff @(posedge clk) begin
      if (rst) begin
         vpipe <= '0;
         wpipe <= '0;
      end else begin
         vpipe <= {vpipe[PD-2:0], 1'b1};
         wpipe <= {wpipe[PD-2:0], wrap_r};
      end
   end

   assign out_valid  = vpipe[PD-1];
   assign cyc_strobe = wpipe[PD-1];
endmodule

// File: rtl/iqp_checker.sv
module iqp_checker #(
   parameter int ACC_W   = 24,
   parameter int SMP_W   = 12,
   parameter int CF_W    = 16,
   parameter int CF_FRAC = 14
) (
   input logic                    clk,
   input logic                    rst,
   input logic [ACC_W-1:0]        ftw,
   input logic signed [CF_W-1:0]  xterm,
   input logic signed [CF_W-1:0]  qgain,
   input logic signed [CF_W-1:0]  dc_i,
   input logic signed [CF_W-1:0]  dc_q,
   input logic signed [SMP_W-1:0] cos_s1,
   input logic signed [SMP_W-1:0] sin_s1,
   input logic signed [SMP_W-1:0] i_out,
   input logic signed [SMP_W-1:0] q_out,
   input logic                    out_valid,
   input logic                    cyc_strobe
);
   localparam logic signed [CF_W-1:0] UNITY = CF_W'(1) <<< CF_FRAC;

   // R3: identity I branch passes the cosine sample through
   p_unity_i_r3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(xterm, 2) == '0 && $past(dc_i, 2) == '0)
      |-> (i_out == $past(cos_s1, 2)));

   // R3: identity Q branch passes the sine sample through
   p_unity_q_r3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(qgain, 2) == UNITY && $past(dc_q, 2) == '0)
      |-> (q_out == $past(sin_s1, 2)));

   // R8: the wrap mark only accompanies valid samples
   p_strobe_valid_r8: assert property (@(posedge clk) disable iff (rst)
      cyc_strobe |-> out_valid);

   // R9: a frozen phase never wraps
   p_idle_nowrap_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(out_valid) && $past(ftw, 1) == '0 && $past(ftw, 2) == '0
       && $past(ftw, 3) == '0 && $past(ftw, 4) == '0) |-> !cyc_strobe);

   // R11: valid holds once reached
   p_valid_hold_r11: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> out_valid);
endmodule

bind iq_tone_precomp iqp_checker #(
   .ACC_W   (ACC_W),
   .SMP_W   (SMP_W),
   .CF_W    (CF_W),
   .CF_FRAC (CF_FRAC)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ftw        (ftw),
   .xterm      (xterm),
   .qgain      (qgain),
   .dc_i       (dc_i),
   .dc_q       (dc_q),
   .cos_s1     (smp[0]),
   .sin_s1     (smp[1]),
   .i_out      (i_out),
   .q_out      (q_out),
   .out_valid  (out_valid),
   .cyc_strobe (cyc_strobe)
);

// File: tb/tb_iq_tone_precomp.sv
`timescale 1ns/1ps
module tb_iq_tone_precomp;
   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [23:0]        ftw = '0;
   logic signed [15:0] cx = 16'sd0;
   logic signed [15:0] cg = 16'sd16384;
   logic signed [15:0] ci = 16'sd0;
   logic signed [15:0] cq = 16'sd0;
   logic signed [11:0] i_out, q_out;
   logic               out_valid, cyc_strobe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   iq_tone_precomp dut (
      .clk(clk), .rst(rst), .ftw(ftw),
      .xterm(cx), .qgain(cg), .dc_i(ci), .dc_q(cq),
      .i_out(i_out), .q_out(q_out),
      .out_valid(out_valid), .cyc_strobe(cyc_strobe)
   );

   // bench phase model and 3-deep history
   logic [23:0] mph, h1, h2, h3;
   logic        mw, w1, w2, w3;
   always @(posedge clk) begin
      if (rst) begin
         mph <= '0; h1 <= '0; h2 <= '0; h3 <= '0;
         mw <= 1'b0; w1 <= 1'b0; w2 <= 1'b0; w3 <= 1'b0;
      end else begin
         {mw, mph} <= {1'b0, mph} + {1'b0, ftw};
         h1 <= mph; h2 <= h1; h3 <= h2;
         w1 <= mw;  w2 <= w1; w3 <= w2;
      end
   end

   function automatic int tone(input int idx);
      int p, qd, k, m;
      p  = idx % 1024;
      qd = p / 256;
      k  = p % 256;
      if (qd == 1 || qd == 3) k = 255 - k;
      m = $rtoi(2047.0 * $sin(6.283185307179586 * (real'(k) + 0.5) / real'(1024)) + 0.5);
      return (qd >= 2) ? -m : m;
   endfunction

   function automatic int sat12(input longint v);
      if (v > 2047)  return 2047;
      if (v < -2048) return -2048;
      return int'(v);
   endfunction

   function automatic int exp_i(input logic [23:0] ph);
      longint c, s, n;
      c = longint'(tone(int'(ph[23:14]) + 256));
      s = longint'(tone(int'(ph[23:14])));
      n = c * 16384 + longint'(cx) * s + longint'(ci) * 2048 + 8192;
      return sat12(n >>> 14);
   endfunction

   function automatic int exp_q(input logic [23:0] ph);
      longint s, n;
      s = longint'(tone(int'(ph[23:14])));
      n = longint'(cg) * s + longint'(cq) * 2048 + 8192;
      return sat12(n >>> 14);
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // one clock of full comparison against the model
   task automatic chk_cycle(input string rq);
      int ei, eq;
      @(negedge clk);
      ei = exp_i(h3);
      eq = exp_q(h3);
      check(out_valid == 1'b1, "R11", "out_valid", int'(out_valid), 1);
      check(int'(i_out) == ei, rq, "i_out", int'(i_out), ei);
      check(int'(q_out) == eq, rq, "q_out", int'(q_out), eq);
      check(cyc_strobe == w3, "R8", "cyc_strobe", int'(cyc_strobe), int'(w3));
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(i_out == '0 && q_out == '0, "R1", "outputs in reset", int'(i_out), 0);
      check(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
      check(cyc_strobe == 1'b0, "R1", "strobe in reset", int'(cyc_strobe), 0);
      ftw = 24'h0A3D71;
      rst = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "valid after edge 1", int'(out_valid), 0);
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "valid after edge 2", int'(out_valid), 0);
      @(negedge clk);
      check(out_valid == 1'b1, "R1", "valid after edge 3", int'(out_valid), 1);
      check(int'(i_out) == tone(256) && int'(q_out) == tone(0), "R2",
            "first sample is phase 0", int'(i_out), tone(256));
   endtask

   task automatic t_identity();
      for (int n = 0; n < 60; n++) chk_cycle("R3");
   endtask

   task automatic t_cross();
      cx = 16'sd4096; ci = -16'sd300;
      settle();
      for (int n = 0; n < 30; n++) chk_cycle("R4");
      cx = -16'sd2500; ci = 16'sd777;
      settle();
      for (int n = 0; n < 30; n++) chk_cycle("R4");
   endtask

   task automatic t_round();
      int c0;
      cx = 16'sd0; ci = 16'sd4;
      settle();
      @(negedge clk);
      c0 = tone(int'(h3[23:14]) + 256);
      check(int'(i_out) == c0 + 1, "R6", "half LSB up", int'(i_out), c0 + 1);
      ci = -16'sd4;
      settle();
      @(negedge clk);
      c0 = tone(int'(h3[23:14]) + 256);
      check(int'(i_out) == c0, "R6", "minus half LSB", int'(i_out), c0);
      ci = 16'sd0;
   endtask

   task automatic t_qbranch();
      cg = 16'sd12288; cq = 16'sd100;
      settle();
      for (int n = 0; n < 30; n++) chk_cycle("R5");
      cg = 16'sd0; cq = 16'sd80;
      settle();
      for (int n = 0; n < 30; n++) begin
         @(negedge clk);
         check(int'(q_out) == 10, "R5", "q with zero gain", int'(q_out), 10);
      end
   endtask

   task automatic t_sat();
      int hi = 0, lo = 0;
      cx = 16'sh7FFF; ci = 16'sh2000;
      cg = 16'sh7FFF; cq = -16'sh2000;
      ftw = 24'h0C0000;
      settle();
      for (int n = 0; n < 80; n++) begin
         chk_cycle("R7");
         if (i_out == 12'sh7FF || q_out == 12'sh7FF) hi++;
         if (i_out == -12'sh800 || q_out == -12'sh800) lo++;
      end
      check(hi > 0, "R7", "upper clip reached", hi, 1);
      check(lo > 0, "R7", "lower clip reached", lo, 1);
      cx = 16'sd0; ci = 16'sd0; cg = 16'sd16384; cq = 16'sd0;
   endtask

   task automatic t_strobe();
      int seen = 0;
      ftw = 24'h100000;
      settle();
      for (int n = 0; n < 64; n++) begin
         chk_cycle("R8");
         if (cyc_strobe) seen++;
      end
      check(seen == 4, "R8", "wraps in 64 clocks", seen, 4);
   endtask

   task automatic t_hold();
      int fi, fq;
      ftw = '0;
      repeat (5) @(negedge clk);
      fi = int'(i_out); fq = int'(q_out);
      for (int n = 0; n < 20; n++) begin
         @(negedge clk);
         check(int'(i_out) == fi && int'(q_out) == fq, "R9", "frozen output",
               int'(i_out), fi);
         check(cyc_strobe == 1'b0, "R9", "no strobe", int'(cyc_strobe), 0);
      end
   endtask

   task automatic t_retune();
      ftw = 24'h054321;
      for (int n = 0; n < 20; n++) chk_cycle("R10");
      ftw = 24'h1F0000;
      for (int n = 0; n < 20; n++) chk_cycle("R10");
      ftw = 24'hFFF000;
      for (int n = 0; n < 20; n++) chk_cycle("R10");
   endtask

   initial begin
      t_reset();
      t_identity();
      t_cross();
      t_round();
      t_qbranch();
      cg = 16'sd16384; cq = 16'sd0;
      t_sat();
      t_strobe();
      t_hold();
      t_retune();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule